// File: doc/BRIEF.md
# Security Context Slot Unit

This unit holds the configuration of hardware security contexts for a single hardware thread. Two slots exist: slot 0 describes the context that is running now, and slot 1 is a staging slot that software prepares and then switches into. Each slot carries a 32-bit key, a 32-bit entry address, a capability mask and a "fresh" flag. The key never leaves the unit in raw form except through the memory image; software identifies it through a 32-bit fold hash.

Operations arrive one at a time on a valid/ready request port. Register-only operations (read a field, generate a key, write the entry, write the capabilities, move a slot) finish in a fixed two-edge window. Store and load walk through a four-word memory image over a held-request memory port. A move or load whose destination is slot 0 performs a context switch: the caller's key hash is captured, all fresh flags drop, and the new entry address is announced on a one-cycle next-PC pulse. Any illegal request raises an error together with its completion pulse and changes nothing.

Top module: `ctx_slot_unit`

## Requirements
- R1: After reset slot 0 holds key RST_KEY (default 0), entry RST_ENTRY (default 32'h0000_1000) and all capability bits set; slot 1 holds zeros and is not fresh; callerHash, opDone, opErr, nextPcValid and memReq are 0 and opReady is 1.
- R2: A request is taken at a rising edge where opValid and opReady are both high; for codes 0 to 4 and 7, opDone is high for exactly one cycle following the next rising edge after that, and opReady is low only in between.
- R3: Opcodes are 0 read, 1 generate key, 2 write entry, 3 write capabilities, 4 move, 5 store, 6 load. A read of slot srcSlot returns on rdData, with opDone, the key hash for field 1, the entry for field 2 and the capability mask zero-extended for field 3; the key hash of k is rotl(k,7) xor k xor 32'h9E37_79B9.
- R4: Key generation into dstSlot other than 0 loads rndKey as the key, marks the slot fresh and copies slot 0's capabilities into it; key generation into slot 0 is an error.
- R5: Writing the entry (from operand) or the capabilities is allowed only on a fresh slot; otherwise it is an error.
- R6: A capability write whose low CAP_W operand bits include any bit absent from slot 0's capabilities is an error; otherwise the mask becomes those bits.
- R7: A move into slot 1 copies key, entry, capabilities and fresh flag from srcSlot, with no next-PC pulse.
- R8: A move or successful load into slot 0 is a switch: callerHash takes the hash of the old slot 0 key, every fresh flag clears, the source slot keeps its contents, and nextPcValid pulses with opDone while nextPc shows the new slot 0 entry. Slot 0 changes in no other way.
- R9: A store of srcSlot writes four 32-bit words at A, A+4, A+8, A+12 where A = operand + sign-extended offset: key, entry, zero-extended capabilities, key hash; it then clears that slot's fresh flag.
- R10: A load reads the same four words; if word 3 differs from the hash of word 0 it is an error and nothing changes, otherwise dstSlot takes the loaded key, entry and capabilities and is not fresh.
- R11: Field 0 on a read and opcode 7 are errors; opErr is only ever high together with opDone, and an erroneous request changes no state.
- R12: memReq stays high with memAddr, memWe and memWdata unchanged until memAck; each acknowledged cycle moves one word.
- R13: A request offered while opReady is low is ignored and produces no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request present |
| opReady | output | 1 | Unit can take a request |
| opCode | input | 3 | Operation code |
| dstSlot | input | SLOT_W | Destination slot |
| srcSlot | input | SLOT_W | Source slot |
| field | input | 2 | Field selector for a read |
| operand | input | 32 | Entry, capability value or base address |
| offset | input | OFF_W | Signed address offset |
| rndKey | input | 32 | Random key source |
| opDone | output | 1 | Completion pulse |
| opErr | output | 1 | Request was illegal |
| rdData | output | 32 | Read result |
| nextPc | output | 32 | Entry of the newly running context |
| nextPcValid | output | 1 | Switch pulse |
| callerHash | output | 32 | Key hash of the previous context |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| memAck | input | 1 | Memory acknowledge |

## Verification
Two functions meet in one cycle in this unit: the completion of a context switch and the legality check of the request taken right after it, which must already use the new running capabilities. The bench provokes it by switching into a context with a reduced mask and at once generating a key and writing a capability bit outside that mask, judging the error flag and the capability read-back. A second overlap is a request arriving while a store is stepping through memory; the bench offers a key generation in mid-store and then checks that no extra completion pulse appears and the key hash is unchanged.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int WORD_W = 32;
  localparam int IMG_WORDS = 4;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_GENKEY = 3'd1,
    OP_WENTRY = 3'd2,
    OP_WCAP   = 3'd3,
    OP_MOVE   = 3'd4,
    OP_STORE  = 3'd5,
    OP_LOAD   = 3'd6
  } ctxOp_e;

  typedef struct packed {
    logic readOut;
    logic genKey;
    logic wrEntry;
    logic wrCap;
    logic moveSlot;
    logic loadCommit;
    logic switchCtx;
    logic clrNew;
    logic grabWord;
  } ctxStrobe_t;

  function automatic logic [WORD_W-1:0] foldHash(input logic [WORD_W-1:0] k);
    return {k[WORD_W-8:0], k[WORD_W-1:WORD_W-7]} ^ k ^ 32'h9E37_79B9;
  endfunction
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int CAP_W  = 8,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IDX_W  = $clog2(IMG_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [SLOT_W-1:0] dstSlot,
  input  logic [SLOT_W-1:0] srcSlot,
  input  logic [1:0]        field,
  input  logic [WORD_W-1:0] operand,
  input  logic [OFF_W-1:0]  offset,
  input  logic              memAck,
  input  logic [SLOTS-1:0]  slotNew,
  input  logic [CAP_W-1:0]  runCap,
  input  logic              loadOk,
  output logic              opReady,
  output logic              opDone,
  output logic              opErr,
  output ctxStrobe_t        stb,
  output logic [SLOT_W-1:0] cmdDst,
  output logic [SLOT_W-1:0] cmdSrc,
  output logic [1:0]        cmdField,
  output logic [WORD_W-1:0] cmdOperand,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_MEM, S_FIN} state_e;

  state_e            state;
  logic [2:0]        cmdOp;
  logic [ADDR_W-1:0] baseAddr;
  logic              illegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cmdOp      <= '0;
      cmdDst     <= '0;
      cmdSrc     <= '0;
      cmdField   <= '0;
      cmdOperand <= '0;
      baseAddr   <= '0;
      wordIdx    <= '0;
      opDone     <= 1'b0;
      opErr      <= 1'b0;
    end else begin
      opDone <= 1'b0;
      opErr  <= 1'b0;
      case (state)
        S_IDLE: if (opValid) begin
          cmdOp      <= opCode;
          cmdDst     <= dstSlot;
          cmdSrc     <= srcSlot;
          cmdField   <= field;
          cmdOperand <= operand;
          baseAddr   <= ADDR_W'(operand) + ADDR_W'($signed(offset));
          wordIdx    <= '0;
          state      <= (opCode == OP_STORE || opCode == OP_LOAD) ? S_MEM : S_EXEC;
        end
        S_EXEC: begin
          opDone <= 1'b1;
          opErr  <= illegal;
          state  <= S_IDLE;
        end
        S_MEM: if (memAck) begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == IDX_W'(IMG_WORDS - 1)) state <= S_FIN;
        end
        default: begin
          opDone <= 1'b1;
          opErr  <= illegal;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (cmdOp)
      OP_READ:   illegal = (cmdField == 2'd0);
      OP_GENKEY: illegal = (cmdDst == '0);
      OP_WENTRY: illegal = !slotNew[cmdDst];
      OP_WCAP:   illegal = !slotNew[cmdDst] || (|(cmdOperand[CAP_W-1:0] & ~runCap));
      OP_MOVE:   illegal = 1'b0;
      OP_STORE:  illegal = 1'b0;
      OP_LOAD:   illegal = !loadOk;
      default:   illegal = 1'b1;
    endcase
  end

  always_comb begin
    stb = '0;
    if (state == S_EXEC && !illegal) begin
      case (cmdOp)
        OP_READ:   stb.readOut = 1'b1;
        OP_GENKEY: stb.genKey  = 1'b1;
        OP_WENTRY: stb.wrEntry = 1'b1;
        OP_WCAP:   stb.wrCap   = 1'b1;
        OP_MOVE: begin
          stb.moveSlot  = 1'b1;
          stb.switchCtx = (cmdDst == '0);
        end
        default: ;
      endcase
    end
    if (state == S_FIN && !illegal) begin
      if (cmdOp == OP_LOAD) begin
        stb.loadCommit = 1'b1;
        stb.switchCtx  = (cmdDst == '0);
      end else begin
        stb.clrNew = 1'b1;
      end
    end
    stb.grabWord = (state == S_MEM) && memAck && (cmdOp == OP_LOAD);
  end

  assign opReady = (state == S_IDLE);
  assign memReq  = (state == S_MEM);
  assign memWe   = (cmdOp == OP_STORE);
  assign memAddr = baseAddr + ADDR_W'({wordIdx, 2'b00});

  // R12: a pending memory request holds its address and direction
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R2: at most one state-changing strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.readOut, stb.genKey, stb.wrEntry, stb.wrCap,
              stb.moveSlot, stb.loadCommit, stb.clrNew, stb.grabWord}));
endmodule

// File: rtl/ctx_dpath.sv
module ctx_dpath
  import ctx_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int CAP_W = 8,
  parameter logic [WORD_W-1:0] RST_KEY   = '0,
  parameter logic [WORD_W-1:0] RST_ENTRY = 32'h0000_1000,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IDX_W  = $clog2(IMG_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctxStrobe_t        stb,
  input  logic [SLOT_W-1:0] cmdDst,
  input  logic [SLOT_W-1:0] cmdSrc,
  input  logic [1:0]        cmdField,
  input  logic [WORD_W-1:0] cmdOperand,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] rndKey,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] callerHash,
  output logic [WORD_W-1:0] nextPc,
  output logic              nextPcValid,
  output logic [SLOTS-1:0]  slotNew,
  output logic [CAP_W-1:0]  runCap,
  output logic              loadOk
);
  logic [WORD_W-1:0] slotKey   [SLOTS];
  logic [WORD_W-1:0] slotEntry [SLOTS];
  logic [CAP_W-1:0]  slotCap   [SLOTS];
  logic              slotFresh [SLOTS];
  logic [WORD_W-1:0] loadBuf   [IMG_WORDS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotKey[i]   <= (i == 0) ? RST_KEY : '0;
        slotEntry[i] <= (i == 0) ? RST_ENTRY : '0;
        slotCap[i]   <= (i == 0) ? '1 : '0;
        slotFresh[i] <= 1'b0;
      end else begin
        if (stb.genKey && cmdDst == SLOT_W'(i)) begin
          slotKey[i]   <= rndKey;
          slotCap[i]   <= slotCap[0];
          slotFresh[i] <= 1'b1;
        end else if (stb.wrEntry && cmdDst == SLOT_W'(i)) begin
          slotEntry[i] <= cmdOperand;
        end else if (stb.wrCap && cmdDst == SLOT_W'(i)) begin
          slotCap[i] <= cmdOperand[CAP_W-1:0];
        end else if (stb.moveSlot && cmdDst == SLOT_W'(i)) begin
          slotKey[i]   <= slotKey[cmdSrc];
          slotEntry[i] <= slotEntry[cmdSrc];
          slotCap[i]   <= slotCap[cmdSrc];
          slotFresh[i] <= slotFresh[cmdSrc];
        end else if (stb.loadCommit && cmdDst == SLOT_W'(i)) begin
          slotKey[i]   <= loadBuf[0];
          slotEntry[i] <= loadBuf[1];
          slotCap[i]   <= loadBuf[2][CAP_W-1:0];
          slotFresh[i] <= 1'b0;
        end else if (stb.clrNew && cmdSrc == SLOT_W'(i)) begin
          slotFresh[i] <= 1'b0;
        end
        if (stb.switchCtx) slotFresh[i] <= 1'b0;
      end
    end
    assign slotNew[i] = slotFresh[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < IMG_WORDS; w++) loadBuf[w] <= '0;
    end else if (stb.grabWord) begin
      loadBuf[wordIdx] <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      callerHash  <= '0;
      nextPc      <= '0;
      nextPcValid <= 1'b0;
    end else begin
      nextPcValid <= 1'b0;
      if (stb.readOut) begin
        case (cmdField)
          2'd1:    rdData <= foldHash(slotKey[cmdSrc]);
          2'd2:    rdData <= slotEntry[cmdSrc];
          default: rdData <= WORD_W'(slotCap[cmdSrc]);
        endcase
      end
      if (stb.switchCtx) begin
        callerHash  <= foldHash(slotKey[0]);
        nextPc      <= stb.moveSlot ? slotEntry[cmdSrc] : loadBuf[1];
        nextPcValid <= 1'b1;
      end
    end
  end

  always_comb begin
    case (wordIdx)
      2'd0:    memWdata = slotKey[cmdSrc];
      2'd1:    memWdata = slotEntry[cmdSrc];
      2'd2:    memWdata = WORD_W'(slotCap[cmdSrc]);
      default: memWdata = foldHash(slotKey[cmdSrc]);
    endcase
  end

  assign runCap = slotCap[0];
  assign loadOk = (foldHash(loadBuf[0]) == loadBuf[3]);

  // R8: the running slot changes only through a switch
  a_r8_slot0_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !stb.switchCtx |=> $stable(slotKey[0]) && $stable(slotEntry[0]) && $stable(slotCap[0]));

  // R6: a committed capability write never exceeds the running mask
  a_r6_cap_shrink: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCap |=> (slotCap[cmdDst] & ~slotCap[0]) == '0);

  // R8: the next-PC announcement lasts one cycle
  a_r8_pc_pulse: assert property (@(posedge clk) disable iff (!rstN)
    nextPcValid |=> !nextPcValid);
endmodule

// File: rtl/ctx_slot_unit.sv
module ctx_slot_unit
  import ctx_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int CAP_W  = 8,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  parameter logic [31:0] RST_KEY   = 32'h0,
  parameter logic [31:0] RST_ENTRY = 32'h0000_1000,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [2:0]        opCode,
  input  logic [SLOT_W-1:0] dstSlot,
  input  logic [SLOT_W-1:0] srcSlot,
  input  logic [1:0]        field,
  input  logic [31:0]       operand,
  input  logic [OFF_W-1:0]  offset,
  input  logic [31:0]       rndKey,
  output logic              opDone,
  output logic              opErr,
  output logic [31:0]       rdData,
  output logic [31:0]       nextPc,
  output logic              nextPcValid,
  output logic [31:0]       callerHash,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);
  localparam int IDX_W = $clog2(IMG_WORDS);

  ctxStrobe_t        stb;
  logic [SLOT_W-1:0] cmdDst, cmdSrc;
  logic [1:0]        cmdField;
  logic [WORD_W-1:0] cmdOperand;
  logic [IDX_W-1:0]  wordIdx;
  logic [SLOTS-1:0]  slotNew;
  logic [CAP_W-1:0]  runCap;
  logic              loadOk;

  ctx_ctrl #(.SLOTS(SLOTS), .CAP_W(CAP_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .dstSlot(dstSlot), .srcSlot(srcSlot), .field(field), .operand(operand),
    .offset(offset), .memAck(memAck), .slotNew(slotNew), .runCap(runCap),
    .loadOk(loadOk), .opReady(opReady), .opDone(opDone), .opErr(opErr),
    .stb(stb), .cmdDst(cmdDst), .cmdSrc(cmdSrc), .cmdField(cmdField),
    .cmdOperand(cmdOperand), .wordIdx(wordIdx), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr)
  );

  ctx_dpath #(.SLOTS(SLOTS), .CAP_W(CAP_W), .RST_KEY(RST_KEY), .RST_ENTRY(RST_ENTRY)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdDst(cmdDst), .cmdSrc(cmdSrc),
    .cmdField(cmdField), .cmdOperand(cmdOperand), .wordIdx(wordIdx),
    .rndKey(rndKey), .memRdata(memRdata), .memWdata(memWdata),
    .rdData(rdData), .callerHash(callerHash), .nextPc(nextPc),
    .nextPcValid(nextPcValid), .slotNew(slotNew), .runCap(runCap),
    .loadOk(loadOk)
  );

  // R8: a switch is announced only with a clean completion
  a_r8_pc_with_done: assert property (@(posedge clk) disable iff (!rstN)
    nextPcValid |-> opDone && !opErr);

  // R11: an error flag never appears without completion
  a_r11_err_done: assert property (@(posedge clk) disable iff (!rstN)
    opErr |-> opDone);
endmodule

// File: tb/ctx_slot_unit_tb.sv
module ctx_slot_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [2:0]  opCode = '0;
  logic        dstSlot = 1'b0, srcSlot = 1'b0;
  logic [1:0]  field = '0;
  logic [31:0] operand = '0;
  logic [11:0] offset = '0;
  logic [31:0] rndKey = '0;
  logic        opDone, opErr, nextPcValid, memReq, memWe;
  logic [31:0] rdData, nextPc, callerHash, memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [31:0] mem [64];

  int nChecks = 0, nFails = 0;

  localparam logic [31:0] K1 = 32'hA5A5_1234;
  localparam logic [31:0] K2 = 32'h0BAD_F00D;

  always #4 clk = ~clk;

  ctx_slot_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opCode(opCode), .dstSlot(dstSlot), .srcSlot(srcSlot), .field(field),
    .operand(operand), .offset(offset), .rndKey(rndKey), .opDone(opDone),
    .opErr(opErr), .rdData(rdData), .nextPc(nextPc), .nextPcValid(nextPcValid),
    .callerHash(callerHash), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && !memAck) begin
      if (memWe) mem[memAddr[7:2]] <= memWdata;
      memRdata <= mem[memAddr[7:2]];
    end
  end

  function automatic logic [31:0] refHash(input logic [31:0] k);
    return ((k << 7) | (k >> 25)) ^ k ^ 32'h9E37_79B9;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        rErr, rPcv;
  logic [31:0] rRd, rPc;
  int          rLat;

  task automatic doOp(input logic [2:0] code, input logic dst, input logic src,
                      input logic [1:0] fld, input logic [31:0] opnd, input logic [11:0] off);
    @(negedge clk);
    opValid = 1'b1; opCode = code; dstSlot = dst; srcSlot = src;
    field = fld; operand = opnd; offset = off;
    @(negedge clk);
    opValid = 1'b0;
    rLat = 0;
    while (!opDone && rLat < 60) begin
      @(negedge clk);
      rLat++;
    end
    rErr = opErr; rRd = rdData; rPcv = nextPcValid; rPc = nextPc;
  endtask

  task automatic readF(input logic slot, input logic [1:0] fld, input string req, input logic [31:0] exp);
    doOp(3'd0, 1'b0, slot, fld, 32'h0, 12'h0);
    check(req, {31'b0, rErr}, 32'h0);
    check(req, rRd, exp);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'b0, opReady}, 32'h1);
    check("R1 done", {31'b0, opDone}, 32'h0);
    check("R1 pcv", {31'b0, nextPcValid}, 32'h0);
    check("R1 memReq", {31'b0, memReq}, 32'h0);
    check("R1 caller", callerHash, 32'h0);
    readF(1'b0, 2'd1, "R1 R3 key0 hash", refHash(32'h0));
    check("R2 latency", rLat, 1);
    readF(1'b0, 2'd2, "R1 entry0", 32'h0000_1000);
    readF(1'b0, 2'd3, "R1 caps0", 32'h0000_00FF);
    readF(1'b1, 2'd2, "R1 entry1", 32'h0);
  endtask

  task automatic t_illegal;
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h5555, 12'h0);
    check("R5 entry on stale", {31'b0, rErr}, 32'h1);
    doOp(3'd3, 1'b1, 1'b0, 2'd0, 32'h1, 12'h0);
    check("R5 caps on stale", {31'b0, rErr}, 32'h1);
    doOp(3'd0, 1'b0, 1'b0, 2'd0, 32'h0, 12'h0);
    check("R11 field0", {31'b0, rErr}, 32'h1);
    doOp(3'd7, 1'b0, 1'b0, 2'd1, 32'h0, 12'h0);
    check("R11 opcode7", {31'b0, rErr}, 32'h1);
    check("R2 latency err", rLat, 1);
    rndKey = 32'h1111_1111;
    doOp(3'd1, 1'b0, 1'b0, 2'd0, 32'h0, 12'h0);
    check("R4 genkey slot0", {31'b0, rErr}, 32'h1);
    check("R11 no pcv", {31'b0, rPcv}, 32'h0);
    readF(1'b0, 2'd1, "R11 key0 kept", refHash(32'h0));
    readF(1'b1, 2'd2, "R11 entry1 kept", 32'h0);
  endtask

  task automatic t_moveOut;
    doOp(3'd4, 1'b1, 1'b0, 2'd0, 32'h0, 12'h0);
    check("R7 move ok", {31'b0, rErr}, 32'h0);
    check("R7 no pcv", {31'b0, rPcv}, 32'h0);
    readF(1'b1, 2'd1, "R7 key copied", refHash(32'h0));
    readF(1'b1, 2'd2, "R7 entry copied", 32'h0000_1000);
    readF(1'b1, 2'd3, "R7 caps copied", 32'hFF);
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h7, 12'h0);
    check("R7 tag copied", {31'b0, rErr}, 32'h1);
  endtask

  task automatic t_genkey;
    rndKey = K1;
    doOp(3'd1, 1'b1, 1'b0, 2'd0, 32'h0, 12'h0);
    check("R4 genkey", {31'b0, rErr}, 32'h0);
    readF(1'b1, 2'd1, "R4 key hash", refHash(K1));
    readF(1'b1, 2'd3, "R4 caps copy", 32'hFF);
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h2000, 12'h0);
    check("R5 entry fresh", {31'b0, rErr}, 32'h0);
    doOp(3'd3, 1'b1, 1'b0, 2'd0, 32'h0F, 12'h0);
    check("R5 caps fresh", {31'b0, rErr}, 32'h0);
    readF(1'b1, 2'd3, "R5 caps value", 32'h0F);
    doOp(3'd3, 1'b1, 1'b0, 2'd0, 32'h1F, 12'h0);
    check("R6 subset of running", {31'b0, rErr}, 32'h0);
    readF(1'b1, 2'd3, "R6 caps value", 32'h1F);
    readF(1'b1, 2'd2, "R5 entry value", 32'h2000);
  endtask

  task automatic t_store;
    int n;
    int extraDone;
    @(negedge clk);
    opValid = 1'b1; opCode = 3'd5; srcSlot = 1'b1; dstSlot = 1'b0;
    operand = 32'h40; offset = 12'h010;
    @(negedge clk);
    opValid = 1'b0;
    @(negedge clk);
    check("R13 busy", {31'b0, opReady}, 32'h0);
    rndKey = 32'hDEAD_0000;
    opValid = 1'b1; opCode = 3'd1; dstSlot = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    n = 0;
    while (!opDone && n < 60) begin
      @(negedge clk);
      n++;
    end
    check("R9 store done", {31'b0, opDone}, 32'h1);
    check("R9 store ok", {31'b0, opErr}, 32'h0);
    extraDone = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (opDone) extraDone++;
    end
    check("R13 no extra done", extraDone, 0);
    check("R9 word key", mem[20], K1);
    check("R9 word entry", mem[21], 32'h2000);
    check("R9 word caps", mem[22], 32'h1F);
    check("R9 word hash", mem[23], refHash(K1));
    check("R12 no stray write", mem[24], 32'h0);
    readF(1'b1, 2'd1, "R13 key unchanged", refHash(K1));
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h9, 12'h0);
    check("R9 tag cleared", {31'b0, rErr}, 32'h1);
  endtask

  task automatic t_switch;
    doOp(3'd4, 1'b0, 1'b1, 2'd0, 32'h0, 12'h0);
    check("R8 move ok", {31'b0, rErr}, 32'h0);
    check("R8 pcv", {31'b0, rPcv}, 32'h1);
    check("R8 pc", rPc, 32'h2000);
    check("R8 caller", callerHash, refHash(32'h0));
    @(negedge clk);
    check("R8 pcv one cycle", {31'b0, nextPcValid}, 32'h0);
    readF(1'b0, 2'd1, "R8 new key0", refHash(K1));
    readF(1'b0, 2'd3, "R8 new caps0", 32'h1F);
    readF(1'b1, 2'd1, "R8 source kept", refHash(K1));
  endtask

  task automatic t_capAfterSwitch;
    rndKey = K2;
    doOp(3'd1, 1'b1, 1'b0, 2'd0, 32'h0, 12'h0);
    check("R4 genkey 2", {31'b0, rErr}, 32'h0);
    readF(1'b1, 2'd3, "R4 caps from new running", 32'h1F);
    doOp(3'd3, 1'b1, 1'b0, 2'd0, 32'h20, 12'h0);
    check("R6 grow rejected", {31'b0, rErr}, 32'h1);
    readF(1'b1, 2'd3, "R6 caps kept", 32'h1F);
    doOp(3'd3, 1'b1, 1'b0, 2'd0, 32'h03, 12'h0);
    check("R6 shrink ok", {31'b0, rErr}, 32'h0);
    readF(1'b1, 2'd3, "R6 caps shrunk", 32'h03);
  endtask

  task automatic t_switchClearsNew;
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h3000, 12'h0);
    check("R5 entry 2", {31'b0, rErr}, 32'h0);
    doOp(3'd4, 1'b0, 1'b1, 2'd0, 32'h0, 12'h0);
    check("R8 pc 2", rPc, 32'h3000);
    check("R8 pcv 2", {31'b0, rPcv}, 32'h1);
    check("R8 caller 2", callerHash, refHash(K1));
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h4000, 12'h0);
    check("R8 fresh cleared", {31'b0, rErr}, 32'h1);
    readF(1'b0, 2'd3, "R8 caps0 after", 32'h03);
  endtask

  task automatic t_load;
    doOp(3'd6, 1'b1, 1'b0, 2'd0, 32'h60, 12'hFF0);
    check("R10 load ok", {31'b0, rErr}, 32'h0);
    check("R10 no pcv", {31'b0, rPcv}, 32'h0);
    readF(1'b1, 2'd1, "R10 key", refHash(K1));
    readF(1'b1, 2'd2, "R10 entry", 32'h2000);
    readF(1'b1, 2'd3, "R10 caps", 32'h1F);
    doOp(3'd2, 1'b1, 1'b0, 2'd0, 32'h1, 12'h0);
    check("R10 not fresh", {31'b0, rErr}, 32'h1);
    mem[23] = mem[23] ^ 32'h1;
    doOp(3'd6, 1'b0, 1'b0, 2'd0, 32'h50, 12'h0);
    check("R10 bad hash", {31'b0, rErr}, 32'h1);
    check("R10 bad no pcv", {31'b0, rPcv}, 32'h0);
    readF(1'b0, 2'd1, "R10 key0 kept", refHash(K2));
    mem[23] = mem[23] ^ 32'h1;
    doOp(3'd6, 1'b0, 1'b0, 2'd0, 32'h50, 12'h0);
    check("R10 switch load", {31'b0, rErr}, 32'h0);
    check("R10 R8 pcv", {31'b0, rPcv}, 32'h1);
    check("R10 R8 pc", rPc, 32'h2000);
    check("R10 R8 caller", callerHash, refHash(K2));
    readF(1'b0, 2'd3, "R10 caps0", 32'h1F);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_moveOut();
    t_genkey();
    t_store();
    t_switch();
    t_capAfterSwitch();
    t_switchClearsNew();
    t_load();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule